// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and one 512K x 8 asynchronous static RAM. The host offers one request at a time: a single-word read or a single-word write, with a 19-bit word address and, for writes, one data byte. The block turns each request into the memory's active-low chip select, output gate and write strobe, holds the address steady for the whole access, and drives the 8-bit bidirectional data bus only while it is writing.

Every access walks through fixed phases: address setup, strobe, data hold (writes only) and bus turnaround. The length of each phase is a parameter counted in clock cycles, so the memory's access, setup, hold and release times can be met at any clock rate. A write is ended by the rising write strobe while chip select is still low, which makes the write strobe the terminating edge that data setup and hold are measured from. Output gate stays high for the whole write, so the write pulse never has to cover the memory releasing the bus. Read data is sampled at the end of the strobe phase and returned with a one-cycle valid pulse. A busy flag tells the host when the next request can be taken.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is low and after it, until a request is accepted, chip select, output gate and write strobe are high (inactive), busy is low and read-valid is low.
- R2: A request is taken only on a clock edge where req_valid is high and busy is low; busy is high from the next cycle until the access ends, and a request offered while busy is high is ignored and writes nothing.
- R3: A write holds chip select low with address and data driven for exactly SETUP_CYC cycles before the write strobe falls, then holds the write strobe low for exactly WR_CYC cycles, then keeps data driven for HOLD_CYC cycles with the strobe high.
- R4: A read holds the output gate low for exactly SETUP_CYC + RD_CYC cycles with the write strobe high, samples the bus in the last of those cycles, and raises read-valid for exactly one cycle with that byte on rd_data.
- R5: Output gate and write strobe are never low in the same cycle, and the block drives the data bus only while chip select is low and the output gate is high.
- R6: The address does not change in any cycle where chip select stays low.
- R7: Every access ends with TURN_CYC cycles in which chip select is high and the bus is released before busy falls, so a write lasts SETUP_CYC + WR_CYC + HOLD_CYC + TURN_CYC busy cycles and a read SETUP_CYC + RD_CYC + TURN_CYC.
- R8: A byte written to an address reads back unchanged until that address is written again, across the full address range 0 to 7FFFF hex.
- R9: Whenever chip select is high, the output gate and the write strobe are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host offers a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | An access is in progress; requests are ignored |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the read byte |
| rd_data | output | 8 | Byte returned by the last read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output gate, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | 19 | Memory address |
| mem_dq | inout | 8 | Memory data bus |

## Verification
The bench runs a seeded random mix of reads and writes over a pool of addresses, which tells apart stale, swapped or dropped bytes through read-back against a shadow copy. Directed cases put writes and reads back to back in both orders, to show the turnaround release and the absence of output gate and write strobe overlap at the boundary, and use the lowest and highest address with all-zero and all-one bytes to catch truncated address or data bits. One case offers a second write while busy and reads its target afterwards to show it was dropped. A cycle monitor measures each strobe and setup run length, so an off-by-one in any phase counter stands out from a data error.

// File: rtl/sram_ctrl_pkg.sv
// Shared types for the asynchronous SRAM access sequencer.
package sram_ctrl_pkg;

    // Phases every access walks through, in order.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_TURN   = 3'd4
    } phase_e;

    // Kind of the access in flight.
    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    // Counter width able to hold the value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
// Down-counter that times one phase.
// Assumes: load carries (length - 1); last is high in the final cycle of the phase.
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Phase ends when the count has reached zero.
    assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
// Phase sequencer: steps IDLE -> SETUP -> STROBE -> (HOLD) -> TURN -> IDLE.
// Assumes: every phase length parameter is at least 1; start is only raised in IDLE.
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int RD_CYC    = 2,
    parameter int WR_CYC    = 2,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  op_e    start_op,
    output phase_e phase_q,
    output phase_e phase_d,
    output op_e    op_d,
    output logic   capture
);

    localparam int MAX_A = (SETUP_CYC > RD_CYC)   ? SETUP_CYC : RD_CYC;
    localparam int MAX_B = (WR_CYC > HOLD_CYC)    ? WR_CYC    : HOLD_CYC;
    localparam int MAX_C = (MAX_A > MAX_B)        ? MAX_A     : MAX_B;
    localparam int MAX_CYC = (MAX_C > TURN_CYC)   ? MAX_C     : TURN_CYC;
    localparam int CNT_W = cnt_width(MAX_CYC);

    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WR    = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN  = CNT_W'(TURN_CYC - 1);

    op_e              op_q;
    logic             last;
    logic             load;
    logic [CNT_W-1:0] load_val;

    // Next phase and the timer reload value for it.
    always_comb begin
        phase_d  = phase_q;
        op_d     = op_q;
        load_val = '0;
        unique case (phase_q)
            PH_IDLE: begin
                if (start) begin
                    phase_d  = PH_SETUP;
                    op_d     = start_op;
                    load_val = LD_SETUP;
                end
            end
            PH_SETUP: begin
                if (last) begin
                    phase_d  = PH_STROBE;
                    load_val = (op_q == OP_WRITE) ? LD_WR : LD_RD;
                end
            end
            PH_STROBE: begin
                if (last) begin
                    phase_d  = (op_q == OP_WRITE) ? PH_HOLD : PH_TURN;
                    load_val = (op_q == OP_WRITE) ? LD_HOLD : LD_TURN;
                end
            end
            PH_HOLD: begin
                if (last) begin
                    phase_d  = PH_TURN;
                    load_val = LD_TURN;
                end
            end
            PH_TURN: begin
                if (last) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    assign load    = (phase_d != phase_q);
    assign capture = (phase_q == PH_STROBE) && (op_q == OP_READ) && last;

    // Phase and operation registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_READ;
        end else begin
            phase_q <= phase_d;
            op_q    <= op_d;
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .last     (last)
    );

    // R3/R4: phases follow their fixed order.
    p_setup_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETUP) |=> (phase_q inside {PH_SETUP, PH_STROBE}));
    p_hold_only_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |-> (op_q == OP_WRITE));
    p_turn_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TURN) |=> (phase_q inside {PH_TURN, PH_IDLE}));

endmodule

// File: rtl/sram_ctrl_io.sv
// Pin stage: registers the memory strobes, address and write data, drives the
// bidirectional bus during writes and captures read data.
// Assumes: phase_d/op_d are the sequencer's next phase and operation, so the
// registered strobes line up with the phase register without a decode glitch.
module sram_ctrl_io
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 1,
    parameter int RD_CYC    = 2,
    parameter int WR_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase_d,
    input  op_e               op_d,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic              dq_oe;
    logic [DATA_W-1:0] wdata_q;

    // Strobes and bus enable decoded from the next phase, then registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            dq_oe    <= 1'b0;
        end else begin
            mem_cs_n <= !(phase_d inside {PH_SETUP, PH_STROBE, PH_HOLD});
            mem_oe_n <= !((op_d == OP_READ) && (phase_d inside {PH_SETUP, PH_STROBE}));
            mem_we_n <= !((op_d == OP_WRITE) && (phase_d == PH_STROBE));
            dq_oe    <= (op_d == OP_WRITE) && (phase_d inside {PH_SETUP, PH_STROBE, PH_HOLD});
        end
    end

    // Address and write byte are latched once, when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
        end
    end

    // Read byte sampled at the end of the strobe phase, flagged for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= mem_dq;
        end
    end

    assign mem_dq = dq_oe ? wdata_q : {DATA_W{1'bz}};

    // Run-length counters used only by the checks below.
    logic [15:0] we_run_q;
    logic [15:0] oe_run_q;

    // Count consecutive low cycles of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_run_q <= '0;
            oe_run_q <= '0;
        end else begin
            we_run_q <= mem_we_n ? 16'd0 : we_run_q + 16'd1;
            oe_run_q <= mem_oe_n ? 16'd0 : oe_run_q + 16'd1;
        end
    end

    p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run_q == 16'(WR_CYC)));
    p_oe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_run_q == 16'(SETUP_CYC + RD_CYC)));
    p_no_oe_we_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));
    p_drive_only_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!mem_cs_n && mem_oe_n));
    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
    p_deselect_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n));

endmodule

// File: rtl/sram_ctrl.sv
// Top of the asynchronous SRAM access sequencer: takes one host request at a
// time and plays it out on the memory pins with parameterised phase lengths.
// Assumes: one 512K x 8 device; every phase length parameter is at least 1.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 1,
    parameter int RD_CYC    = 2,
    parameter int WR_CYC    = 2,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);

    if (SETUP_CYC < 1 || RD_CYC < 1 || WR_CYC < 1 || HOLD_CYC < 1 || TURN_CYC < 1) begin : g_bad_len
        $error("every phase length must be at least one cycle");
    end

    phase_e phase_q;
    phase_e phase_d;
    op_e    op_d;
    logic   capture;
    logic   accept;

    assign busy   = (phase_q != PH_IDLE);
    assign accept = req_valid && !busy;

    sram_ctrl_seq #(
        .SETUP_CYC (SETUP_CYC),
        .RD_CYC    (RD_CYC),
        .WR_CYC    (WR_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .TURN_CYC  (TURN_CYC)
    ) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .start_op (req_write ? OP_WRITE : OP_READ),
        .phase_q  (phase_q),
        .phase_d  (phase_d),
        .op_d     (op_d),
        .capture  (capture)
    );

    sram_ctrl_io #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .RD_CYC    (RD_CYC),
        .WR_CYC    (WR_CYC)
    ) io_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_d   (phase_d),
        .op_d      (op_d),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .mem_cs_n  (mem_cs_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    p_rd_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    p_idle_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mem_cs_n);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (mem_cs_n && !rd_valid && !busy));

endmodule

// File: tb/sram_ctrl_tb.sv
// Bench for sram_ctrl: behavioural 512K x 8 memory, shadow copy, cycle monitor.
module sram_ctrl_tb_top;

    localparam int S  = 2;
    localparam int RD = 3;
    localparam int WR = 2;
    localparam int H  = 1;
    localparam int T  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rd_valid;
    logic [7:0]  rd_data;
    logic        cs_n, oe_n, we_n;
    logic [18:0] maddr;
    wire  [7:0]  dq;

    int nchecks = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sram_ctrl #(
        .SETUP_CYC(S), .RD_CYC(RD), .WR_CYC(WR), .HOLD_CYC(H), .TURN_CYC(T)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(cs_n),
        .mem_oe_n(oe_n), .mem_we_n(we_n), .mem_addr(maddr), .mem_dq(dq)
    );

    // Behavioural memory: drives the bus on a read, stores on the write strobe rise.
    logic [7:0] mem    [logic [18:0]];
    logic [7:0] shadow [logic [18:0]];
    logic [7:0] model_q = '0;

    always @(negedge clk) model_q = mem.exists(maddr) ? mem[maddr] : 8'h00;
    assign dq = (rst_n && !cs_n && !oe_n && we_n) ? model_q : 8'bz;
    always @(posedge we_n) if (rst_n && !cs_n) mem[maddr] = dq;

    function automatic logic [7:0] expect_rd(input logic [18:0] a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchecks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Cycle monitor on the memory pins.
    int we_run = 0, oe_run = 0, setup_run = 0, cs_high_run = 1000;
    logic prev_we = 1'b1, prev_oe = 1'b1, prev_cs = 1'b1;
    logic [18:0] prev_addr = '0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(!( !oe_n && !we_n), "R5 oe/we overlap", {oe_n, we_n}, 2'b11);
            if (cs_n) check(we_n && oe_n, "R9 strobes idle when deselected", {oe_n, we_n}, 2'b11);
            if (!cs_n && !prev_cs) check(maddr == prev_addr, "R6 address stable", maddr, prev_addr);
            if (!cs_n && prev_cs) check(cs_high_run >= T, "R7 turnaround length", cs_high_run, T);
            if (!we_n && prev_we) check(setup_run == S, "R3 write setup length", setup_run, S);
            if (we_n && !prev_we) check(we_run == WR, "R3 write pulse length", we_run, WR);
            if (oe_n && !prev_oe) check(oe_run == S + RD, "R4 output gate length", oe_run, S + RD);
            we_run      = we_n ? 0 : we_run + 1;
            oe_run      = oe_n ? 0 : oe_run + 1;
            setup_run   = (!cs_n && we_n && oe_n) ? setup_run + 1 : 0;
            cs_high_run = cs_n ? cs_high_run + 1 : 0;
            prev_we = we_n; prev_oe = oe_n; prev_cs = cs_n; prev_addr = maddr;
        end
    end

    // Offer one request and follow it to the end; optionally offer a stray write while busy.
    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         input bit stray, output int bcyc, output bit got, output logic [7:0] rdat);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy, "R2 busy after accept", busy, 1);
        bcyc = 0; got = 0; rdat = '0;
        while (busy) begin
            bcyc++;
            if (rd_valid) begin got = 1; rdat = rd_data; end
            if (stray && bcyc == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = a ^ 19'h1; req_wdata = ~d;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d, input bit stray);
        int bc; bit g; logic [7:0] r;
        issue(1'b1, a, d, stray, bc, g, r);
        check(bc == S + WR + H + T, "R7 write busy length", bc, S + WR + H + T);
        shadow[a] = d;
    endtask

    task automatic do_read(input logic [18:0] a);
        int bc; bit g; logic [7:0] r;
        issue(1'b0, a, 8'h00, 1'b0, bc, g, r);
        check(g, "R4 read valid pulse", g, 1);
        check(r == expect_rd(a), "R8 read-back data", r, expect_rd(a));
        check(bc == S + RD + T, "R7 read busy length", bc, S + RD + T);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            nerr++; nchecks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

    initial begin
        logic [18:0] pool [34];
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: quiet pins during reset.
        check(cs_n && oe_n && we_n, "R1 strobes in reset", {cs_n, oe_n, we_n}, 3'b111);
        check(!busy && !rd_valid, "R1 busy/valid in reset", {busy, rd_valid}, 2'b00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n && oe_n && we_n && !busy && !rd_valid, "R1 idle after reset",
              {cs_n, oe_n, we_n, busy, rd_valid}, 5'b11100);

        // Directed corners: address extremes, all-zero/all-one data, both turn orders.
        do_write(19'h00000, 8'hFF, 1'b0);
        do_write(19'h7FFFF, 8'h00, 1'b0);
        do_read(19'h00000);
        do_read(19'h7FFFF);
        do_write(19'h7FFFF, 8'hA5, 1'b0);
        do_read(19'h7FFFF);
        do_write(19'h00001, 8'h3C, 1'b0);
        // R2: stray write to 00001 while busy must be dropped.
        do_write(19'h00000, 8'h5A, 1'b1);
        do_read(19'h00001);
        do_read(19'h00000);

        // Seeded random mix over an address pool.
        for (int i = 0; i < 32; i++) pool[i] = 19'($urandom);
        pool[32] = 19'h00000;
        pool[33] = 19'h7FFFF;
        for (int i = 0; i < 400; i++) begin
            logic [18:0] a;
            a = pool[$urandom % 34];
            if (($urandom % 2 == 0) && shadow.exists(a)) do_read(a);
            else do_write(a, 8'($urandom), 1'b0);
        end
        for (int i = 0; i < 34; i++) if (shadow.exists(pool[i])) do_read(pool[i]);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchecks);
            $finish;
        end
    end

endmodule